// File: doc/BRIEF.md
# UART register block with serializer and deserializer

This block is a small serial port seen by a processor through a 32-bit, word-addressed register window. Software places a character in the data register, and the block sends it on `txd` as an asynchronous frame. The frame length follows the word-length field, and the bit period follows the divisor register. Characters that arrive on `rxd` are framed with the same divisor and word length. A good frame is placed in the receive register and flagged in the status register. One level interrupt line reports transmitter-ready and receive-ready events. The identification register records which event was the last to fire.

Every register is 8 bits wide and reads back zero-extended. Register offsets are 4 bytes apart. A single access starts whenever `bus_sel` is high on a clock edge. Read data comes back registered in the cycle after the access. An access to an offset outside the window does not stop the bus. It reads as zero and pulses `bus_err`. The bus has no back-pressure: each access completes in one cycle. A character written while another frame is still going out waits in a one-deep slot and follows that frame.

Top module: `uart_regblk`

## Requirements
- R1: Register offsets are data 0x00, interrupt enable 0x04, identification 0x08, line control 0x0C, modem control 0x10, line status 0x14, modem status 0x18 and divisor 0x1C. Writes keep bits 7:0 of the write data, and reads return the stored byte zero-extended. Reading 0x00 returns the receive register.
- R2: After reset every register reads zero except line status, which reads 0x20. After reset `irq` is low, `txd` is high and `bus_err` is low.
- R3: Read data appears on `bus_rdata` one cycle after the read access. It holds its value until the next read, even when writes happen in between.
- R4: An access is unmapped when the offset is above 0x1C or its two low bits are not zero. `bus_err` is high in the cycle after an unmapped access and is low in the cycle after any other access or idle cycle. An unmapped read returns 0, and an unmapped write changes no register.
- R5: A write to offset 0x00 clears line status bit 5 (transmit empty) and clears identification bit 1. The character is then queued for sending.
- R6: A frame is one low start bit, then N = 5 + (line control bits 1:0) data bits sent LSB first, then one high stop bit. Data bits above N are dropped. Each bit lasts divisor+1 clock cycles, and `txd` is high when no frame is being sent.
- R7: When the last queued character finishes, line status bit 5 is set and identification is loaded with 0x02. `irq` goes high if interrupt-enable bit 1 is set.
- R8: A write to interrupt enable with bit 1 set, made while status bit 5 is set, ORs 0x02 into identification and raises `irq` on the next cycle. A write with bit 1 clear lowers `irq` on the next cycle. No other bus access lowers `irq`.
- R9: A received frame with a high stop bit stores its N data bits, zero-extended, in the receive register and sets status bit 0. If interrupt-enable bit 0 is set, identification is loaded with 0x04 and `irq` goes high. A frame whose stop bit is low is discarded.
- R10: Reading offset 0x00 returns the received character and clears status bit 0.
- R11: A character written while a frame is being sent goes out right after that frame. Status bit 5 stays clear until this queued character has finished.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one access per high cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data, bits 7:0 used |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle flag for an unmapped access |
| rxd | input | 1 | Serial input, synchronous to clk, idle high |
| txd | output | 1 | Serial output, idle high |
| irq | output | 1 | Level interrupt request |

## Verification
The properties assume that `rxd` is already synchronous to `clk` and that the bus inputs are known and stable from one edge to the next. They also assume that at most one access happens per cycle. They further assume that line control and divisor stay constant while a frame is on the line, in either direction. The bench follows these rules: it changes every input on the falling clock edge, it issues only single-cycle accesses, and it reprograms the word length and the divisor only when transmitter and receiver are both idle. The bench drives received frames at exactly divisor+1 cycles per bit, so the receiver's mid-bit sampling point always lands inside the intended bit.

// File: rtl/uart_regblk_pkg.sv
package uart_regblk_pkg;
  localparam int REG_W = 8;
  localparam int BUS_W = 32;

  // register byte offsets (word stride)
  localparam logic [5:0] OFS_DATA  = 6'h00;
  localparam logic [5:0] OFS_IEN   = 6'h04;
  localparam logic [5:0] OFS_ISRC  = 6'h08;
  localparam logic [5:0] OFS_LCTL  = 6'h0C;
  localparam logic [5:0] OFS_MCTL  = 6'h10;
  localparam logic [5:0] OFS_LSTAT = 6'h14;
  localparam logic [5:0] OFS_MSTAT = 6'h18;
  localparam logic [5:0] OFS_DIV   = 6'h1C;

  localparam int IEN_RX  = 0;
  localparam int IEN_TX  = 1;
  localparam int ST_RXAV = 0;
  localparam int ST_TXMT = 5;
  localparam int SRC_TXB = 1;

  localparam logic [REG_W-1:0] SRC_TX_CODE = 8'h02;
  localparam logic [REG_W-1:0] SRC_RX_CODE = 8'h04;
  localparam logic [REG_W-1:0] LSTAT_RST   = 8'h20;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  // data bits per character from the 2-bit length code
  function automatic logic [3:0] char_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction
endpackage

// File: rtl/uart_regblk_tx.sv
module uart_regblk_tx #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       data,
  input  logic [1:0]       wlen,
  input  logic [DIV_W-1:0] div,
  output logic             txd,
  output logic             busy,
  output logic             done
);
  import uart_regblk_pkg::*;

  logic [9:0]       frame_q;
  logic [3:0]       left_q;
  logic [DIV_W-1:0] cnt_q;
  logic             busy_q, done_q;

  logic [3:0] nbits;
  logic [7:0] keep;
  logic [9:0] frame_d;

  always_comb begin
    nbits   = char_bits(wlen);
    keep    = 8'hFF >> (2'd3 - wlen);
    frame_d = (10'h3FF << (nbits + 4'd1)) | {1'b0, data & keep, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '1;
      left_q  <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        frame_q <= frame_d;
        left_q  <= nbits + 4'd2;
        cnt_q   <= div;
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          if (left_q == 4'd1) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            frame_q <= {1'b1, frame_q[9:1]};
            left_q  <= left_q - 4'd1;
            cnt_q   <= div;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign txd  = busy_q ? frame_q[0] : 1'b1;
  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/uart_regblk_rx.sv
module uart_regblk_rx #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  input  logic [1:0]       wlen,
  input  logic [DIV_W-1:0] div,
  output logic             valid,
  output logic [7:0]       char_out
);
  import uart_regblk_pkg::*;

  rx_state_e        st_q;
  logic [DIV_W-1:0] cnt_q;
  logic [2:0]       idx_q;
  logic [7:0]       sh_q;
  logic             valid_q;
  logic [7:0]       char_q;

  logic [DIV_W:0] half;
  logic [3:0]     nbits;

  always_comb begin
    half  = ({1'b0, div} + 1'b1) >> 1;
    nbits = char_bits(wlen);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      valid_q <= 1'b0;
      char_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      case (st_q)
        RX_IDLE: if (!rxd) begin
          idx_q <= '0;
          if (half == '0) begin
            st_q  <= RX_DATA;
            cnt_q <= div;
          end else begin
            st_q  <= RX_START;
            cnt_q <= DIV_W'(half - 1'b1);
          end
        end
        RX_START: if (cnt_q == '0) begin
          st_q  <= rxd ? RX_IDLE : RX_DATA;
          cnt_q <= div;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        RX_DATA: if (cnt_q == '0) begin
          sh_q  <= {rxd, sh_q[7:1]};
          cnt_q <= div;
          idx_q <= idx_q + 3'd1;
          if (idx_q == 3'(nbits - 4'd1)) st_q <= RX_STOP;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        default: if (cnt_q == '0) begin
          st_q <= RX_IDLE;
          if (rxd) begin
            valid_q <= 1'b1;
            char_q  <= sh_q >> (2'd3 - wlen);
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      endcase
    end
  end

  assign valid    = valid_q;
  assign char_out = char_q;
endmodule

// File: rtl/uart_regblk.sv
module uart_regblk #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  input  logic              rxd,
  output logic              txd,
  output logic              irq
);
  import uart_regblk_pkg::*;

  localparam int DIV_W = REG_W;

  logic [REG_W-1:0] ien_q, isrc_q, lctl_q, mctl_q, lstat_q, mstat_q, div_q, thr_q, rbr_q;
  logic [REG_W-1:0] isrc_d, lstat_d;
  logic             irq_q, irq_d, tx_pend_q, err_q;
  logic [BUS_W-1:0] rdata_q;
  logic [REG_W-1:0] rd_mux;
  logic [REG_W-1:0] wbyte;

  logic       mapped;
  logic [2:0] idx;
  logic       wr, rd;
  logic       wr_thr, wr_ien, wr_isrc, wr_lctl, wr_mctl, wr_lstat, wr_mstat, wr_div, rd_rbr;
  logic       tx_busy, tx_done, tx_start, tx_evt;
  logic       rx_valid;
  logic [7:0] rx_char;
  logic       unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[BUS_W-1:REG_W];
  assign wbyte   = bus_wdata[REG_W-1:0];
  assign mapped  = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 5) == '0);
  assign idx     = bus_addr[4:2];
  assign wr      = bus_sel && mapped && bus_we;
  assign rd      = bus_sel && mapped && !bus_we;
  assign wr_thr   = wr && (idx == OFS_DATA[4:2]);
  assign wr_ien   = wr && (idx == OFS_IEN[4:2]);
  assign wr_isrc  = wr && (idx == OFS_ISRC[4:2]);
  assign wr_lctl  = wr && (idx == OFS_LCTL[4:2]);
  assign wr_mctl  = wr && (idx == OFS_MCTL[4:2]);
  assign wr_lstat = wr && (idx == OFS_LSTAT[4:2]);
  assign wr_mstat = wr && (idx == OFS_MSTAT[4:2]);
  assign wr_div   = wr && (idx == OFS_DIV[4:2]);
  assign rd_rbr   = rd && (idx == OFS_DATA[4:2]);

  assign tx_start = tx_pend_q && !tx_busy;
  // completion counts only when nothing else waits and no new write lands now
  assign tx_evt   = tx_done && !tx_pend_q && !wr_thr;

  uart_regblk_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .data(thr_q),
    .wlen(lctl_q[1:0]), .div(div_q), .txd(txd), .busy(tx_busy), .done(tx_done)
  );

  uart_regblk_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .wlen(lctl_q[1:0]), .div(div_q),
    .valid(rx_valid), .char_out(rx_char)
  );

  always_comb begin
    lstat_d = lstat_q;
    if (wr_lstat) lstat_d = wbyte;
    if (rd_rbr)   lstat_d[ST_RXAV] = 1'b0;
    if (rx_valid) lstat_d[ST_RXAV] = 1'b1;
    if (tx_evt)   lstat_d[ST_TXMT] = 1'b1;
    if (wr_thr)   lstat_d[ST_TXMT] = 1'b0;

    isrc_d = isrc_q;
    if (wr_isrc) isrc_d = wbyte;
    if (wr_thr)  isrc_d[SRC_TXB] = 1'b0;
    if (wr_ien && wbyte[IEN_TX] && lstat_q[ST_TXMT]) isrc_d[SRC_TXB] = 1'b1;
    if (tx_evt) isrc_d = SRC_TX_CODE;
    if (rx_valid && ien_q[IEN_RX]) isrc_d = SRC_RX_CODE;

    irq_d = irq_q;
    if ((tx_evt && ien_q[IEN_TX]) || (rx_valid && ien_q[IEN_RX])) irq_d = 1'b1;
    if (wr_ien) begin
      if (!wbyte[IEN_TX])             irq_d = 1'b0;
      else if (lstat_q[ST_TXMT])      irq_d = 1'b1;
    end
  end

  always_comb begin
    case (idx)
      OFS_DATA[4:2]:  rd_mux = rbr_q;
      OFS_IEN[4:2]:   rd_mux = ien_q;
      OFS_ISRC[4:2]:  rd_mux = isrc_q;
      OFS_LCTL[4:2]:  rd_mux = lctl_q;
      OFS_MCTL[4:2]:  rd_mux = mctl_q;
      OFS_LSTAT[4:2]: rd_mux = lstat_q;
      OFS_MSTAT[4:2]: rd_mux = mstat_q;
      default:        rd_mux = div_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q     <= '0;
      isrc_q    <= '0;
      lctl_q    <= '0;
      mctl_q    <= '0;
      lstat_q   <= LSTAT_RST;
      mstat_q   <= '0;
      div_q     <= '0;
      thr_q     <= '0;
      rbr_q     <= '0;
      irq_q     <= 1'b0;
      tx_pend_q <= 1'b0;
      err_q     <= 1'b0;
      rdata_q   <= '0;
    end else begin
      if (wr_ien)   ien_q   <= wbyte;
      if (wr_lctl)  lctl_q  <= wbyte;
      if (wr_mctl)  mctl_q  <= wbyte;
      if (wr_mstat) mstat_q <= wbyte;
      if (wr_div)   div_q   <= wbyte;
      if (wr_thr)   thr_q   <= wbyte;
      if (rx_valid) rbr_q   <= rx_char;
      if (wr_thr)        tx_pend_q <= 1'b1;
      else if (tx_start) tx_pend_q <= 1'b0;
      lstat_q <= lstat_d;
      isrc_q  <= isrc_d;
      irq_q   <= irq_d;
      err_q   <= bus_sel && !mapped;
      if (bus_sel && !bus_we) rdata_q <= mapped ? {{(BUS_W-REG_W){1'b0}}, rd_mux} : '0;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;
  assign irq       = irq_q;
endmodule

// File: rtl/uart_regblk_chk.sv
module uart_regblk_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              ien_tx_bit,
  input logic              bus_err,
  input logic              irq,
  input logic              txd,
  input logic              tx_busy,
  input logic              tx_done,
  input logic              tx_pend,
  input logic              rx_valid,
  input logic [7:0]        lstat
);
  logic bad_acc, thr_wr, rbr_rd, ien_wr;
  assign bad_acc = bus_sel && ((bus_addr > ADDR_W'(8'h1C)) || (bus_addr[1:0] != 2'b00));
  assign thr_wr  = bus_sel && bus_we && (bus_addr == '0);
  assign rbr_rd  = bus_sel && !bus_we && (bus_addr == '0);
  assign ien_wr  = bus_sel && bus_we && (bus_addr == ADDR_W'(8'h04));

  // R4
  a_r4_err_after_bad: assert property (@(posedge clk) disable iff (!rst_n)
    bad_acc |=> bus_err);
  // R4
  a_r4_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_acc |=> !bus_err);
  // R5
  a_r5_thr_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !lstat[5]);
  // R6
  a_r6_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
  // R7
  a_r7_done_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !tx_pend && !thr_wr) |=> lstat[5]);
  // R8
  a_r8_ien_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_wr && !ien_tx_bit) |=> !irq);
  // R10
  a_r10_read_clears_avail: assert property (@(posedge clk) disable iff (!rst_n)
    (rbr_rd && !rx_valid) |=> !lstat[0]);
endmodule

bind uart_regblk uart_regblk_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .ien_tx_bit(bus_wdata[1]), .bus_err(bus_err), .irq(irq), .txd(txd),
  .tx_busy(tx_busy), .tx_done(tx_done), .tx_pend(tx_pend_q), .rx_valid(rx_valid),
  .lstat(lstat_q)
);

// File: tb/uart_regblk_bench.sv
module uart_regblk_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  // {length code[17:16], divisor[15:8], character[7:0]}
  localparam logic [17:0] TX_VEC [6] = '{
    {2'd3, 8'd0, 8'hA5}, {2'd0, 8'd0, 8'hFF}, {2'd1, 8'd2, 8'hC6},
    {2'd2, 8'd1, 8'h81}, {2'd3, 8'd3, 8'h3C}, {2'd0, 8'd4, 8'hEA}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err, rxd, txd, irq;
  int          n_checks = 0, n_fail = 0;

  initial rxd = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regblk u_uart_regblk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .rxd(rxd), .txd(txd), .irq(irq)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic e);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata; e = bus_err;
    bus_sel = 1'b0;
  endtask

  task automatic get_frame(input int nb, input int p, output logic [7:0] ch, output logic ok);
    int w;
    w = 0; ch = '0; ok = 1'b1;
    while (txd !== 1'b0 && w < 200) begin @(negedge clk); w++; end
    if (w >= 200) ok = 1'b0;
    for (int i = 0; i < nb; i++) begin
      repeat (p) @(negedge clk);
      ch[i] = txd;
    end
    repeat (p) @(negedge clk);
    if (txd !== 1'b1) ok = 1'b0;
  endtask

  task automatic wait_empty(output logic [31:0] st);
    logic e;
    st = '0;
    for (int k = 0; k < 100; k++) begin
      rd(8'h14, st, e);
      if (st[5]) break;
    end
  endtask

  task automatic send_rx(input logic [7:0] ch, input int nb, input int p, input logic stopv);
    rxd = 1'b0;
    repeat (p) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd = ch[i];
      repeat (p) @(negedge clk);
    end
    rxd = stopv;
    repeat (p) @(negedge clk);
    rxd = 1'b1;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic        e, ok;
    logic [7:0]  ch;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    check("R2", "txd idle", {31'd0, txd}, 32'd1);
    check("R2", "irq low", {31'd0, irq}, 32'd0);
    check("R2", "err low", {31'd0, bus_err}, 32'd0);
    for (int r = 0; r < 8; r++) begin
      rd(8'(r * 4), d, e);
      check("R2", $sformatf("reset reg %0d", r), d, (r == 5) ? 32'h20 : 32'h0);
    end

    // R1 write and read back
    wr(8'h0C, 32'h0000_00A5); rd(8'h0C, d, e); check("R1", "line ctl", d, 32'hA5);
    wr(8'h10, 32'hFFFF_FF11); rd(8'h10, d, e); check("R1", "modem ctl low byte", d, 32'h11);
    wr(8'h18, 32'h3C);        rd(8'h18, d, e); check("R1", "modem stat", d, 32'h3C);
    wr(8'h1C, 32'h07);        rd(8'h1C, d, e); check("R1", "divisor", d, 32'h07);
    wr(8'h08, 32'h81);        rd(8'h08, d, e); check("R1", "ident", d, 32'h81);
    wr(8'h0C, 32'h03); wr(8'h1C, 32'h00);

    // R4 unmapped accesses
    rd(8'h20, d, e); check("R4", "above map data", d, 32'h0); check("R4", "above map err", {31'd0, e}, 32'd1);
    @(negedge clk);  check("R4", "err one cycle", {31'd0, bus_err}, 32'd0);
    rd(8'h0E, d, e); check("R4", "misaligned data", d, 32'h0); check("R4", "misaligned err", {31'd0, e}, 32'd1);
    wr(8'h0D, 32'h00);
    check("R4", "write err", {31'd0, bus_err}, 32'd1);
    wr(8'h24, 32'h55);
    rd(8'h0C, d, e); check("R4", "line ctl untouched", d, 32'h03);
    check("R4", "mapped read no err", {31'd0, e}, 32'd0);

    // R3 read data holds across writes
    wr(8'h10, 32'h66);
    check("R3", "rdata held", bus_rdata, 32'h03);

    // R5 R6 R7 transmit vectors
    for (int v = 0; v < 6; v++) begin
      logic [1:0] wl; logic [7:0] dv, cv, expc; int nb;
      wl = TX_VEC[v][17:16]; dv = TX_VEC[v][15:8]; cv = TX_VEC[v][7:0];
      nb = 5 + int'(wl);
      expc = cv & (8'hFF >> (3 - int'(wl)));
      wr(8'h0C, {30'd0, wl});
      wr(8'h1C, {24'd0, dv});
      wr(8'h00, {24'd0, cv});
      rd(8'h14, d, e);
      check("R5", $sformatf("vec %0d empty cleared", v), {31'd0, d[5]}, 32'd0);
      get_frame(nb, int'(dv) + 1, ch, ok);
      check("R6", $sformatf("vec %0d framing", v), {31'd0, ok}, 32'd1);
      check("R6", $sformatf("vec %0d char", v), {24'd0, ch}, {24'd0, expc});
      wait_empty(d);
      check("R7", $sformatf("vec %0d empty set", v), {31'd0, d[5]}, 32'd1);
      rd(8'h08, d, e);
      check("R7", $sformatf("vec %0d ident", v), d, 32'h02);
      check("R7", $sformatf("vec %0d irq masked", v), {31'd0, irq}, 32'd0);
    end

    // R8 enable while empty
    wr(8'h08, 32'h00);
    wr(8'h04, 32'h02);
    check("R8", "irq on enable", {31'd0, irq}, 32'd1);
    rd(8'h08, d, e); check("R8", "ident tx bit", d, 32'h02);
    wr(8'h10, 32'h01);
    check("R8", "irq kept by other write", {31'd0, irq}, 32'd1);
    wr(8'h04, 32'h00);
    check("R8", "irq dropped", {31'd0, irq}, 32'd0);

    // R7 R8 enable while busy, then completion
    wr(8'h0C, 32'h03); wr(8'h1C, 32'h04);
    wr(8'h00, 32'h55);
    wr(8'h04, 32'h02);
    check("R8", "no irq while busy", {31'd0, irq}, 32'd0);
    get_frame(8, 5, ch, ok);
    check("R6", "enabled frame char", {24'd0, ch}, 32'h55);
    wait_empty(d);
    check("R7", "irq at completion", {31'd0, irq}, 32'd1);
    wr(8'h04, 32'h00);

    // R11 queued second character
    wr(8'h1C, 32'h01);
    wr(8'h00, 32'h96);
    wr(8'h00, 32'h4B);
    get_frame(8, 2, ch, ok);
    check("R11", "first char", {24'd0, ch}, 32'h96);
    rd(8'h14, d, e);
    check("R11", "empty still clear", {31'd0, d[5]}, 32'd0);
    get_frame(8, 2, ch, ok);
    check("R11", "queued char", {24'd0, ch}, 32'h4B);
    check("R11", "queued framing", {31'd0, ok}, 32'd1);
    wait_empty(d);
    check("R11", "empty after queue", {31'd0, d[5]}, 32'd1);

    // R9 R10 receive, 8 bits, interrupt on
    wr(8'h04, 32'h00);
    wr(8'h04, 32'h01);
    wr(8'h1C, 32'h03);
    send_rx(8'hA7, 8, 4, 1'b1);
    repeat (6) @(negedge clk);
    check("R9", "rx irq", {31'd0, irq}, 32'd1);
    rd(8'h14, d, e); check("R9", "rx avail", d, 32'h21);
    rd(8'h08, d, e); check("R9", "rx ident", d, 32'h04);
    rd(8'h00, d, e); check("R10", "rx char", d, 32'hA7);
    rd(8'h14, d, e); check("R10", "avail cleared", d, 32'h20);

    // R9 six-bit word, interrupt off
    wr(8'h04, 32'h00);
    wr(8'h0C, 32'h01);
    send_rx(8'h2B, 6, 4, 1'b1);
    repeat (6) @(negedge clk);
    check("R9", "no irq when disabled", {31'd0, irq}, 32'd0);
    rd(8'h14, d, e); check("R9", "6-bit avail", d, 32'h21);
    rd(8'h00, d, e); check("R10", "6-bit char", d, 32'h2B);

    // R9 bad stop bit discarded
    send_rx(8'h1A, 6, 4, 1'b0);
    repeat (12) @(negedge clk);
    rd(8'h14, d, e); check("R9", "framing error dropped", d, 32'h20);
    rd(8'h00, d, e); check("R9", "rbr unchanged", d, 32'h2B);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule